// File: doc/BRIEF.md
# Partitioned Translation Buffer with Entry Locking

A fully associative buffer of recent address translations. Every entry stores a page-aligned virtual tag, a 3-bit page-size code (page size is 8 KiB × 8^code), a partition id, a context id, a real-translation flag, a lock bit, a used bit and a data word that holds the physical page data. One command per cycle may be issued on `op_i`: insert, demap of one page, demap of a whole context, or demap of every unlocked entry in a partition. A lookup is requested separately on `lk_req_i` and shares the request fields with the command.

On insert, every valid entry whose page overlaps the new page in the same translation space is invalidated first. The victim is then picked in this order: an explicit index, then the lowest-numbered free entry, then a round-robin search that steps over locked entries. Used bits follow the inserts and the lookups that set them, and are cleared back to one bit when they would all be set. An indexed read port returns the tag and data words of any entry for diagnostics. `ENTRIES` may be at most 64 and `VA_W` must lie between 14 and 55.

Top module: `tlb_part`

## Requirements
- R1: A lookup hits an entry only when the entry is valid, its partition and real flag equal the request, the request address lies inside the entry's page, and the context ids are equal; a request with the real flag set ignores the context id.
- R2: The lookup result appears on `lk_vld_o`, `lk_hit_o`, `lk_idx_o` and `lk_data_o` one clock edge after the request. A miss gives `lk_hit_o` = 0. After reset `lk_vld_o` is 0. Several hits report the lowest index.
- R3: A lookup requested in the same cycle as any command (`op_i` not 0) is dropped: `lk_vld_o` stays 0 on the next cycle.
- R4: An inserted entry stores the request address with its page-offset bits (the low 13 + 3 × size bits) cleared.
- R5: Before an insert writes its victim, every valid entry with the same partition and real flag whose page overlaps the new page is invalidated. For non-real entries the context id must also match.
- R6: An insert with `idx_vld_i` = 1 writes entry `idx_i`. Otherwise it writes the lowest-numbered entry that is invalid after the overlap invalidation.
- R7: With no free entry, the insert takes the first unlocked entry found from the round-robin pointer plus one upward, wrapping round. The pointer is 0 after reset and moves to each entry chosen this way. When every entry is locked, the last entry is written and the pointer does not move.
- R8: An inserted entry is valid and used. If that makes every used bit set, all used bits are cleared except the new entry's.
- R9: A lookup hit sets the entry's used bit only when `lk_upd_i` = 1. If that makes every used bit set, all used bits are cleared except the hit entry's. Invalidating an entry clears its used bit.
- R10: Demap page (`op_i` = 2) invalidates the entries that a lookup with the same fields would hit.
- R11: Demap context (`op_i` = 3) invalidates every entry whose partition and context equal the request, locked or not.
- R12: Demap all (`op_i` = 4) invalidates every valid, unlocked entry of the request partition. Locked entries and other partitions are kept.
- R13: `rd_tag_o` for a valid entry holds the context id in [12:0], the tag in [VA_W-1:13], the lock bit in [55], the inverted size code in [58:56], the used bit in [59], the real flag in [60] and the partition id in [63:61]; all other bits are 0. `rd_data_o` is the data word. Both read all ones for an invalid entry. Command codes: 0 none, 1 insert, 2 demap page, 3 demap context, 4 demap all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command code |
| lk_req_i | input | 1 | Lookup request |
| lk_upd_i | input | 1 | Lookup hit sets used bit |
| va_i | input | VA_W | Virtual address |
| part_i | input | 3 | Partition id |
| ctx_i | input | 13 | Context id |
| real_i | input | 1 | Real-translation flag |
| sz_i | input | 3 | Page-size code (insert) |
| lock_i | input | 1 | Lock bit (insert) |
| data_i | input | DATA_W | Data word (insert) |
| idx_vld_i | input | 1 | Use explicit insert index |
| idx_i | input | IW | Explicit insert index |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IW | Index of hit entry |
| lk_data_o | output | DATA_W | Data word of hit entry (0 on miss) |
| rd_idx_i | input | IW | Diagnostic read index |
| rd_tag_o | output | 64 | Tag word of entry `rd_idx_i` |
| rd_data_o | output | DATA_W | Data word of entry `rd_idx_i` |

## Verification
The bench probes every field of the hit rule one at a time, so a comparator that drops the context or real term, or that tests the page at the wrong width, returns a false hit. It inserts a large page over a small one to show overlap invalidation; a design without it keeps a stale duplicate entry. It fills the buffer so that the round-robin search must step past a locked entry, and then locks every entry, which catches a design that evicts a locked entry or stalls. It also follows the used bits through a wrap and through lookups with and without the update flag, and it checks that a locked entry is kept by demap all but removed by demap context.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int CTX_W    = 13;
  localparam int PART_W   = 3;
  localparam int SZ_W     = 3;
  localparam int OFS_MIN  = 13;

  localparam logic [2:0] OP_NONE     = 3'd0;
  localparam logic [2:0] OP_INSERT   = 3'd1;
  localparam logic [2:0] OP_DMP_PAGE = 3'd2;
  localparam logic [2:0] OP_DMP_CTX  = 3'd3;
  localparam logic [2:0] OP_DMP_ALL  = 3'd4;

  localparam int TG_LOCK = 55;
  localparam int TG_SZ   = 56;
  localparam int TG_USED = 59;
  localparam int TG_REAL = 60;
  localparam int TG_PART = 61;

  // page offset mask: 8 KiB * 8^sz
  function automatic logic [63:0] ofs_mask(input logic [SZ_W-1:0] sz);
    int n;
    n = OFS_MIN + 3 * int'(sz);
    return (64'd1 << n) - 64'd1;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 40
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] lock_i,
  input  logic [ENTRIES-1:0] real_a_i,
  input  logic [VA_W-1:0]    tag_a_i  [ENTRIES],
  input  logic [SZ_W-1:0]    sz_a_i   [ENTRIES],
  input  logic [PART_W-1:0]  part_a_i [ENTRIES],
  input  logic [CTX_W-1:0]   ctx_a_i  [ENTRIES],
  input  logic [VA_W-1:0]    va_i,
  input  logic [SZ_W-1:0]    sz_i,
  input  logic [PART_W-1:0]  part_i,
  input  logic [CTX_W-1:0]   ctx_i,
  input  logic               real_i,
  output logic [ENTRIES-1:0] hit_o,
  output logic [ENTRIES-1:0] ovl_o,
  output logic [ENTRIES-1:0] ctx_o,
  output logic [ENTRIES-1:0] pall_o
);
  logic [VA_W-1:0] new_m;
  assign new_m = VA_W'(ofs_mask(sz_i));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [VA_W-1:0] ent_m, cmb_m;
    logic same_p, same_c, space;
    assign ent_m  = VA_W'(ofs_mask(sz_a_i[e]));
    assign cmb_m  = ent_m | new_m;
    assign same_p = part_a_i[e] == part_i;
    assign same_c = ctx_a_i[e] == ctx_i;
    assign space  = valid_i[e] && same_p && (real_a_i[e] == real_i) && (real_i || same_c);
    assign hit_o[e]  = space && ((va_i & ~ent_m) == tag_a_i[e]);
    // aligned pages overlap iff equal above the larger mask
    assign ovl_o[e]  = space && ((va_i & ~cmb_m) == (tag_a_i[e] & ~cmb_m));
    assign ctx_o[e]  = valid_i[e] && same_p && same_c;
    assign pall_o[e] = valid_i[e] && !lock_i[e] && same_p;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] free_i,
  input  logic [ENTRIES-1:0] lock_i,
  input  logic [IW-1:0]      last_i,
  input  logic               idx_vld_i,
  input  logic [IW-1:0]      idx_i,
  output logic [IW-1:0]      vic_o,
  output logic               rr_o
);
  logic          free_any, rr_any;
  logic [IW-1:0] free_idx, rr_idx;

  always_comb begin
    free_any = |free_i;
    free_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--)
      if (free_i[k]) free_idx = IW'(k);
    rr_any = 1'b0;
    rr_idx = IW'(ENTRIES - 1);
    // nearest unlocked entry after the pointer wins
    for (int k = ENTRIES; k >= 1; k--)
      if (!lock_i[(int'(last_i) + k) % ENTRIES]) begin
        rr_any = 1'b1;
        rr_idx = IW'((int'(last_i) + k) % ENTRIES);
      end
    if (idx_vld_i) begin
      vic_o = idx_i;
      rr_o  = 1'b0;
    end else if (free_any) begin
      vic_o = free_idx;
      rr_o  = 1'b0;
    end else begin
      vic_o = rr_idx;
      rr_o  = rr_any;
    end
  end
endmodule

// File: rtl/tlb_part.sv
module tlb_part import tlb_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 40,
  parameter int DATA_W  = 64,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic              lk_req_i,
  input  logic              lk_upd_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [PART_W-1:0] part_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic              real_i,
  input  logic [SZ_W-1:0]   sz_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              idx_vld_i,
  input  logic [IW-1:0]     idx_i,
  output logic              lk_vld_o,
  output logic              lk_hit_o,
  output logic [IW-1:0]     lk_idx_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [63:0]       rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [ENTRIES-1:0] valid_q, lock_q, used_q, real_q;
  logic [VA_W-1:0]    tag_q  [ENTRIES];
  logic [SZ_W-1:0]    sz_q   [ENTRIES];
  logic [PART_W-1:0]  part_q [ENTRIES];
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [IW-1:0]      last_q;

  logic [ENTRIES-1:0] hit, ovl, ctxm, pall, kill;
  logic [ENTRIES-1:0] valid_mid, used_mid, valid_d, used_d;
  logic [IW-1:0]      victim, hit_idx;
  logic               rr_pick, ins, lk_go;

  assign ins   = op_i == OP_INSERT;
  assign lk_go = lk_req_i && (op_i == OP_NONE);

  tlb_match #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_match (
    .valid_i(valid_q), .lock_i(lock_q), .real_a_i(real_q),
    .tag_a_i(tag_q), .sz_a_i(sz_q), .part_a_i(part_q), .ctx_a_i(ctx_q),
    .va_i(va_i), .sz_i(sz_i), .part_i(part_i), .ctx_i(ctx_i), .real_i(real_i),
    .hit_o(hit), .ovl_o(ovl), .ctx_o(ctxm), .pall_o(pall)
  );

  always_comb begin
    unique case (op_i)
      OP_INSERT:   kill = ovl;
      OP_DMP_PAGE: kill = hit;
      OP_DMP_CTX:  kill = ctxm;
      OP_DMP_ALL:  kill = pall;
      default:     kill = '0;
    endcase
  end

  assign valid_mid = valid_q & ~kill;
  assign used_mid  = used_q & ~kill;

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .free_i(~valid_mid), .lock_i(lock_q), .last_i(last_q),
    .idx_vld_i(idx_vld_i), .idx_i(idx_i), .vic_o(victim), .rr_o(rr_pick)
  );

  always_comb begin
    hit_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--)
      if (hit[k]) hit_idx = IW'(k);
  end

  always_comb begin
    valid_d = valid_mid;
    used_d  = used_mid;
    if (ins) begin
      valid_d[victim] = 1'b1;
      used_d[victim]  = 1'b1;
      if (&used_d) begin
        used_d         = '0;
        used_d[victim] = 1'b1;
      end
    end else if (lk_go && lk_upd_i && |hit) begin
      used_d[hit_idx] = 1'b1;
      if (&used_d) begin
        used_d          = '0;
        used_d[hit_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      used_q    <= '0;
      lock_q    <= '0;
      real_q    <= '0;
      last_q    <= '0;
      lk_vld_o  <= 1'b0;
      lk_hit_o  <= 1'b0;
      lk_idx_o  <= '0;
      lk_data_o <= '0;
    end else begin
      valid_q  <= valid_d;
      used_q   <= used_d;
      lk_vld_o <= lk_go;
      if (lk_go) begin
        lk_hit_o  <= |hit;
        lk_idx_o  <= hit_idx;
        lk_data_o <= (|hit) ? data_q[hit_idx] : '0;
      end
      if (ins) begin
        lock_q[victim] <= lock_i;
        real_q[victim] <= real_i;
        if (rr_pick) last_q <= victim;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins) begin
      tag_q[victim]  <= va_i & ~VA_W'(ofs_mask(sz_i));
      sz_q[victim]   <= sz_i;
      part_q[victim] <= part_i;
      ctx_q[victim]  <= ctx_i;
      data_q[victim] <= data_i;
    end
  end

  always_comb begin
    rd_tag_o  = '1;
    rd_data_o = '1;
    if (valid_q[rd_idx_i]) begin
      rd_tag_o                     = '0;
      rd_tag_o[CTX_W-1:0]          = ctx_q[rd_idx_i];
      rd_tag_o[VA_W-1:OFS_MIN]     = tag_q[rd_idx_i][VA_W-1:OFS_MIN];
      rd_tag_o[TG_LOCK]            = lock_q[rd_idx_i];
      rd_tag_o[TG_SZ+SZ_W-1:TG_SZ] = ~sz_q[rd_idx_i];
      rd_tag_o[TG_USED]            = used_q[rd_idx_i];
      rd_tag_o[TG_REAL]            = real_q[rd_idx_i];
      rd_tag_o[63:TG_PART]         = part_q[rd_idx_i];
      rd_data_o                    = data_q[rd_idx_i];
    end
  end

  assert_rsp_only_lookup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_vld_o |-> $past(lk_req_i && op_i == OP_NONE))
    else $error("lookup response without a lone lookup");

  assert_used_implies_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q & ~valid_q) == '0)
    else $error("used bit on invalid entry");

  assert_insert_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins |=> valid_q[$past(victim)])
    else $error("inserted entry not valid");

  if (ENTRIES > 1) begin : g_full_chk
    assert_used_never_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(&used_q))
      else $error("all used bits set");
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_lock_chk
    assert_lock_holds_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_DMP_ALL && valid_q[e] && lock_q[e]) |=> valid_q[e])
      else $error("locked entry lost on demap all");
  end
endmodule

// File: tb/tb_tlb_part.sv
`timescale 1ns/1ps
module tb_tlb_part;
  import tlb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic        lk_req_i = 1'b0, lk_upd_i = 1'b0;
  logic [39:0] va_i = '0;
  logic [2:0]  part_i = '0;
  logic [12:0] ctx_i = '0;
  logic        real_i = 1'b0;
  logic [2:0]  sz_i = '0;
  logic        lock_i = 1'b0;
  logic [63:0] data_i = '0;
  logic        idx_vld_i = 1'b0;
  logic [2:0]  idx_i = '0;
  logic        lk_vld_o, lk_hit_o;
  logic [2:0]  lk_idx_o;
  logic [63:0] lk_data_o;
  logic [2:0]  rd_idx_i = '0;
  logic [63:0] rd_tag_o, rd_data_o;

  int n_chk = 0, n_fail = 0;
  localparam logic [63:0] DB = 64'hD000_0000_0000_0000;
  localparam logic [63:0] UMASK = ~(64'd1 << 59);

  always #10 clk = ~clk;

  tlb_part #(.ENTRIES(8), .VA_W(40), .DATA_W(64)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .lk_req_i(lk_req_i), .lk_upd_i(lk_upd_i),
    .va_i(va_i), .part_i(part_i), .ctx_i(ctx_i), .real_i(real_i), .sz_i(sz_i),
    .lock_i(lock_i), .data_i(data_i), .idx_vld_i(idx_vld_i), .idx_i(idx_i),
    .lk_vld_o(lk_vld_o), .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o), .lk_data_o(lk_data_o),
    .rd_idx_i(rd_idx_i), .rd_tag_o(rd_tag_o), .rd_data_o(rd_data_o)
  );

  typedef struct packed {
    logic [39:0] va; logic [2:0] p; logic [12:0] c; logic r;
    logic h; logic [2:0] ix; logic [63:0] d;
  } lkv_t;

  localparam lkv_t LKV [9] = '{
    '{40'h0012344010, 3'd1, 13'd5,  1'b0, 1'b1, 3'd0, DB | 64'h12345FFF},
    '{40'h0012344010, 3'd1, 13'd6,  1'b0, 1'b0, 3'd0, 64'h0},
    '{40'h0012344010, 3'd2, 13'd5,  1'b0, 1'b0, 3'd0, 64'h0},
    '{40'h0012344010, 3'd1, 13'd5,  1'b1, 1'b0, 3'd0, 64'h0},
    '{40'h0012346000, 3'd1, 13'd5,  1'b0, 1'b0, 3'd0, 64'h0},
    '{40'h002000FFF8, 3'd1, 13'd99, 1'b1, 1'b1, 3'd1, DB | 64'h20000000},
    '{40'h0020010000, 3'd1, 13'd7,  1'b1, 1'b0, 3'd0, 64'h0},
    '{40'h0030000100, 3'd2, 13'd5,  1'b0, 1'b1, 3'd2, DB | 64'h30000000},
    '{40'h0040000000, 3'd1, 13'd5,  1'b0, 1'b1, 3'd6, DB | 64'h40000000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_tag(logic [39:0] va, logic [2:0] s, logic [2:0] p,
                                          logic [12:0] c, logic r, logic lk);
    logic [63:0] m, t;
    m = (64'd1 << (13 + 3 * int'(s))) - 64'd1;
    t = {24'h0, va} & ~m;
    t[12:0] = c; t[55] = lk; t[58:56] = ~s; t[60] = r; t[63:61] = p;
    return t;
  endfunction

  task automatic rd(input int ix, output logic [63:0] t, output logic [63:0] d);
    rd_idx_i = 3'(ix);
    #1;
    t = rd_tag_o;
    d = rd_data_o;
  endtask

  task automatic chk_tag(input string req, input int ix, input logic [63:0] exp);
    logic [63:0] t, d;
    rd(ix, t, d);
    chk(req, (exp == '1) ? t : (t & UMASK), exp);
  endtask

  task automatic chk_used(input string req, input int ix, input logic exp);
    logic [63:0] t, d;
    rd(ix, t, d);
    chk(req, {63'd0, t[59]}, {63'd0, exp});
  endtask

  task automatic cmd(input logic [2:0] o, input logic [39:0] va, input logic [2:0] p,
                     input logic [12:0] c, input logic r, input logic [2:0] s,
                     input logic lk, input logic iv, input logic [2:0] ix);
    @(negedge clk);
    op_i = o; va_i = va; part_i = p; ctx_i = c; real_i = r; sz_i = s;
    lock_i = lk; idx_vld_i = iv; idx_i = ix; data_i = DB | {24'h0, va};
    @(negedge clk);
    op_i = OP_NONE; idx_vld_i = 1'b0; lock_i = 1'b0;
  endtask

  task automatic look(input logic [39:0] va, input logic [2:0] p, input logic [12:0] c,
                      input logic r, input logic upd);
    @(negedge clk);
    lk_req_i = 1'b1; lk_upd_i = upd; va_i = va; part_i = p; ctx_i = c; real_i = r;
    @(negedge clk);
    lk_req_i = 1'b0; lk_upd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] t, d;
    repeat (2) @(negedge clk);
    // R2 R13: reset state
    chk("R2 reset lk_vld", {63'd0, lk_vld_o}, 64'd0);
    rd(0, t, d);
    chk("R13 reset tag all ones", t, '1);
    chk("R13 reset data all ones", d, '1);
    rst_ni = 1'b1;

    // R6 R4 R8: fill lowest free entries, one explicit
    cmd(OP_INSERT, 40'h0012345FFF, 3'd1, 13'd5, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R4 R6 entry0 tag", 0, exp_tag(40'h0012345FFF, 3'd0, 3'd1, 13'd5, 1'b0, 1'b0));
    chk_used("R8 new entry used", 0, 1'b1);
    cmd(OP_INSERT, 40'h0020000000, 3'd1, 13'd7, 1'b1, 3'd1, 1'b0, 1'b0, 3'd0);
    cmd(OP_INSERT, 40'h0030000000, 3'd2, 13'd5, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0);
    cmd(OP_INSERT, 40'h0040000000, 3'd1, 13'd5, 1'b0, 3'd0, 1'b0, 1'b1, 3'd6);
    chk_tag("R6 explicit index 6", 6, exp_tag(40'h0040000000, 3'd0, 3'd1, 13'd5, 1'b0, 1'b0));
    chk_tag("R4 R13 entry1 tag", 1, exp_tag(40'h0020000000, 3'd1, 3'd1, 13'd7, 1'b1, 1'b0));

    // R1 R2: lookup vector table
    foreach (LKV[i]) begin
      look(LKV[i].va, LKV[i].p, LKV[i].c, LKV[i].r, 1'b0);
      chk($sformatf("R2 vec%0d valid", i), {63'd0, lk_vld_o}, 64'd1);
      chk($sformatf("R1 vec%0d hit", i), {63'd0, lk_hit_o}, {63'd0, LKV[i].h});
      if (LKV[i].h) begin
        chk($sformatf("R1 vec%0d idx", i), {61'd0, lk_idx_o}, {61'd0, LKV[i].ix});
        chk($sformatf("R2 vec%0d data", i), lk_data_o, LKV[i].d);
      end
    end

    // R3: lookup alongside insert is dropped
    @(negedge clk);
    op_i = OP_INSERT; va_i = 40'h0050000000; part_i = 3'd1; ctx_i = 13'd5; real_i = 1'b0;
    sz_i = 3'd0; idx_vld_i = 1'b1; idx_i = 3'd7; data_i = DB | 64'h50000000; lk_req_i = 1'b1;
    @(negedge clk);
    op_i = OP_NONE; idx_vld_i = 1'b0; lk_req_i = 1'b0;
    chk("R3 dropped lookup", {63'd0, lk_vld_o}, 64'd0);
    chk_tag("R3 insert still done", 7, exp_tag(40'h0050000000, 3'd0, 3'd1, 13'd5, 1'b0, 1'b0));

    // R8: used wrap
    cmd(OP_INSERT, 40'h0070000000, 3'd3, 13'd1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    cmd(OP_INSERT, 40'h0071000000, 3'd3, 13'd1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_used("R8 entry0 used before wrap", 0, 1'b1);
    cmd(OP_INSERT, 40'h0072000000, 3'd3, 13'd1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R6 lowest free is 5", 5, exp_tag(40'h0072000000, 3'd0, 3'd3, 13'd1, 1'b0, 1'b0));
    chk_used("R8 newest keeps used", 5, 1'b1);
    chk_used("R8 others cleared", 0, 1'b0);

    // R9: update flag
    look(40'h0012344000, 3'd1, 13'd5, 1'b0, 1'b0);
    chk_used("R9 no update leaves used", 0, 1'b0);
    look(40'h0012344000, 3'd1, 13'd5, 1'b0, 1'b1);
    chk_used("R9 update sets used", 0, 1'b1);

    // R7: round robin, skip locked entry 2
    cmd(OP_INSERT, 40'h0060000000, 3'd1, 13'd5, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R7 rr picks 1", 1, exp_tag(40'h0060000000, 3'd0, 3'd1, 13'd5, 1'b0, 1'b0));
    cmd(OP_INSERT, 40'h0061000000, 3'd1, 13'd5, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R7 rr skips locked, picks 3", 3, exp_tag(40'h0061000000, 3'd0, 3'd1, 13'd5, 1'b0, 1'b0));
    chk_tag("R7 locked entry kept", 2, exp_tag(40'h0030000000, 3'd0, 3'd2, 13'd5, 1'b0, 1'b1));

    // R5: large page over small one
    cmd(OP_INSERT, 40'h0012340000, 3'd1, 13'd5, 1'b0, 3'd1, 1'b0, 1'b1, 3'd4);
    chk_tag("R5 overlapped entry0 gone", 0, '1);
    chk_tag("R5 new entry4", 4, exp_tag(40'h0012340000, 3'd1, 3'd1, 13'd5, 1'b0, 1'b0));
    chk_tag("R5 disjoint entry6 kept", 6, exp_tag(40'h0040000000, 3'd0, 3'd1, 13'd5, 1'b0, 1'b0));
    look(40'h0012344010, 3'd1, 13'd5, 1'b0, 1'b0);
    chk("R5 lookup hits 4", {60'd0, lk_hit_o, lk_idx_o}, {60'd0, 1'b1, 3'd4});

    // R10: demap page
    cmd(OP_DMP_PAGE, 40'h0060000000, 3'd1, 13'd5, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    rd(1, t, d);
    chk("R10 demapped tag", t, '1);
    chk("R13 invalid data all ones", d, '1);
    chk_tag("R10 neighbour kept", 3, exp_tag(40'h0061000000, 3'd0, 3'd1, 13'd5, 1'b0, 1'b0));

    // R11: demap context
    cmd(OP_INSERT, 40'h0068000000, 3'd1, 13'd9, 1'b0, 3'd0, 1'b1, 1'b1, 3'd1);
    cmd(OP_DMP_CTX, 40'h0, 3'd1, 13'd5, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R11 ctx5 entry6 gone", 6, '1);
    chk_tag("R11 ctx5 entry3 gone", 3, '1);
    chk_tag("R11 ctx9 kept", 1, exp_tag(40'h0068000000, 3'd0, 3'd1, 13'd9, 1'b0, 1'b1));
    chk_tag("R11 other part kept", 2, exp_tag(40'h0030000000, 3'd0, 3'd2, 13'd5, 1'b0, 1'b1));

    // R12: demap all
    cmd(OP_INSERT, 40'h0069000000, 3'd1, 13'd9, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0);
    cmd(OP_DMP_ALL, 40'h0, 3'd1, 13'd0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R12 unlocked gone", 0, '1);
    chk_tag("R12 locked kept", 1, exp_tag(40'h0068000000, 3'd0, 3'd1, 13'd9, 1'b0, 1'b1));
    chk_tag("R12 other part kept", 5, exp_tag(40'h0072000000, 3'd0, 3'd3, 13'd1, 1'b0, 1'b0));

    // R11: locked entry removed by context demap
    cmd(OP_DMP_CTX, 40'h0, 3'd2, 13'd5, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R11 locked entry gone", 2, '1);

    // R7: all locked -> last entry
    for (int i = 0; i < 8; i++)
      cmd(OP_INSERT, 40'h00A0000000 + (40'(i) << 24), 3'd4, 13'd2, 1'b0, 3'd0, 1'b1, 1'b1, 3'(i));
    cmd(OP_INSERT, 40'h00B0000000, 3'd4, 13'd2, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
    chk_tag("R7 all locked writes last", 7, exp_tag(40'h00B0000000, 3'd0, 3'd4, 13'd2, 1'b0, 1'b0));
    chk_tag("R7 all locked others kept", 6, exp_tag(40'h00A6000000, 3'd0, 3'd4, 13'd2, 1'b0, 1'b1));

    finish_run();
  end
endmodule